// File: doc/BRIEF.md
# Per-Processor Pending Interrupt Word Bank

This block keeps one 32-bit pending word for each processor in a multiprocessor system, up to sixteen. Software reaches each processor's word through its own 4 KB address page. Inside that page, one word register shows the pending state. A second register clears pending bits where the written value holds ones, and a third sets them. Only the upper fifteen bits, 31 down to 17, can be changed from the bus.

Hardware also writes into the words. Each processor has a local timer line whose level is copied into a fixed pending bit. A group of external request lines is watched for edges. A rising edge sets the bit for that line's level in the word of the processor currently named by the target input. A falling edge clears that bit in the word of whichever processor is targeted at that moment.

All pending words are brought out on a flat vector, which feeds the level-combining logic downstream. The bus is a single-cycle register port: a write takes effect at the clock edge, and a read returns combinationally from the current address.

Top module: `pend_bank`

## Requirements
- R1: After reset every pending word is zero, and a read of any processor's view register returns zero.
- R2: The processor is chosen by address bits 15:12 and the register by address bits 3:2. A read with register index 0 returns that processor's pending word. Reads with index 1, 2 or 3 return zero.
- R3: A write with register index 1 clears each pending bit of the addressed word whose bit in (write data AND 0xFFFE0000) is 1. Bits 16:0, including the timer bit, are never cleared this way.
- R4: A write with register index 2 ORs (write data AND 0xFFFE0000) into the addressed word. Bits 16:0 are never set this way.
- R5: Writes with register index 0 or 3 change no pending word.
- R6: A bus write changes only the word of the processor selected by its address page.
- R7: Each processor's pending bit at position TMR_LEVEL (default 14, mask 0x00004000) equals that processor's timer input as sampled at the previous clock edge.
- R8: External request line i has level i+1 (line 0 maps to bit 1, line 2 to bit 3). A rising edge sets bit (1 << level) in the word of the processor named by `tgt_cpu` in that cycle. A falling edge clears that bit in the word of the processor targeted in its own cycle.
- R9: When a bus write, a request edge and a timer level all reach the same word in one cycle, they are applied in order: the bus operation first, then the request edge, then the timer level. Every effect that does not overlap with another is therefore kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_addr | input | 16 | Byte address: page selects the processor, bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| tmr_lvl | input | NCPU | Per-processor local timer levels |
| src_lvl | input | NSRC | External request lines |
| tgt_cpu | input | log2(NCPU) | Processor that receives external requests |
| pend_flat | output | NCPU*32 | All pending words, processor 0 in the low bits |

## Verification
The bench writes all-ones patterns to the clear and set registers. A design that dropped the 0xFFFE0000 mask would disturb bit 16 and below, or would erase the timer and request bits. Writes to index 0 and index 3 are checked: a design that decoded only address bit 2 would treat them as clears or sets. Writes to processors 0, 3 and 15 are compared against one another, which exposes an error in choosing the page bits.

For request lines, the target is moved between the rising and the falling edge. This shows that the clear lands on the newly targeted word while the set stays in the old one, which a level-following design would get wrong. Same-cycle collisions are then checked: a timer change together with a bus set, and a request edge together with a bus clear. An arbiter that dropped one of the two updates would lose a bit.

// File: rtl/pend_pkg.sv
package pend_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] SW_MASK = 32'hFFFE_0000;

    typedef enum logic [1:0] {
        IDX_VIEW = 2'd0,
        IDX_CLR  = 2'd1,
        IDX_SET  = 2'd2,
        IDX_RSVD = 2'd3
    } reg_idx_e;

    function automatic int unsigned src_level(input int unsigned i);
        return (i % 15) + 1;
    endfunction
endpackage

// File: rtl/pend_decode.sv
module pend_decode
    import pend_pkg::*;
#(
    parameter int unsigned NCPU  = 16,
    parameter int unsigned CPU_W = $clog2(NCPU)
) (
    input  logic             wen_i,
    input  logic [15:0]      addr_i,
    output logic [CPU_W-1:0] cpu_o,
    output reg_idx_e         idx_o,
    output logic [NCPU-1:0]  clr_sel_o,
    output logic [NCPU-1:0]  set_sel_o
);
    logic unused_addr;
    assign unused_addr = ^{addr_i[1:0], addr_i[11:4], addr_i[15:12]};

    assign cpu_o = addr_i[12 +: CPU_W];
    assign idx_o = reg_idx_e'(addr_i[3:2]);

    for (genvar c = 0; c < NCPU; c++) begin : g_sel
        assign clr_sel_o[c] = wen_i && (cpu_o == CPU_W'(c)) && (idx_o == IDX_CLR);
        assign set_sel_o[c] = wen_i && (cpu_o == CPU_W'(c)) && (idx_o == IDX_SET);
    end

    always_comb begin
        assert_one_window_R6: assert ($onehot0(clr_sel_o | set_sel_o));
        assert_no_view_write_R5: assert (!((idx_o == IDX_VIEW || idx_o == IDX_RSVD)
                                           && |(clr_sel_o | set_sel_o)));
    end
endmodule

// File: rtl/pend_src.sv
module pend_src
    import pend_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    output logic [WORD_W-1:0] set_o,
    output logic [WORD_W-1:0] clr_o
);
    logic [NSRC-1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    always_comb begin
        set_o = '0;
        clr_o = '0;
        for (int unsigned i = 0; i < NSRC; i++) begin
            if (src_i[i] && !src_q[i]) set_o[src_level(i)] = 1'b1;
            if (!src_i[i] && src_q[i]) clr_o[src_level(i)] = 1'b1;
        end
    end

    assert_edge_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o & clr_o & ~{WORD_W{1'b0}}) == '0 || NSRC > 15);
endmodule

// File: rtl/pend_word.sv
module pend_word
    import pend_pkg::*;
#(
    parameter int unsigned TMR_LEVEL = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              set_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] src_set_i,
    input  logic [WORD_W-1:0] src_clr_i,
    input  logic              tmr_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [WORD_W-1:0] TMR_BIT = WORD_W'(1) << TMR_LEVEL;
    localparam logic [WORD_W-1:0] LOW_HW  = ~SW_MASK & ~TMR_BIT;

    logic [WORD_W-1:0] word_q, word_d;
    logic              live_q;

    // Applied in order: bus operation, request edge, timer level.
    always_comb begin
        word_d = word_q;
        if (clr_i) word_d = word_d & ~(wdata_i & SW_MASK);
        if (set_i) word_d = word_d |  (wdata_i & SW_MASK);
        word_d = (word_d & ~src_clr_i) | src_set_i;
        if (tmr_i) word_d = word_d | TMR_BIT;
        else       word_d = word_d & ~TMR_BIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            live_q <= 1'b0;
        end else begin
            word_q <= word_d;
            live_q <= 1'b1;
        end
    end

    assign word_o = word_q;

    assert_timer_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (((word_q & TMR_BIT) != '0) == $past(tmr_i)));
    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && clr_i) |=> ((word_q & $past(wdata_i) & SW_MASK) == '0));
    assert_set_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && set_i) |=> ((word_q & $past(wdata_i) & SW_MASK) == ($past(wdata_i) & SW_MASK)));
    assert_low_bits_hw_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ((src_set_i | src_clr_i) & LOW_HW) == '0)
        |=> ((word_q & LOW_HW) == ($past(word_q) & LOW_HW)));
endmodule

// File: rtl/pend_bank.sv
module pend_bank
    import pend_pkg::*;
#(
    parameter int unsigned NCPU      = 16,
    parameter int unsigned NSRC      = 8,
    parameter int unsigned TMR_LEVEL = 14,
    parameter int unsigned CPU_W     = $clog2(NCPU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wen,
    input  logic [15:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NCPU-1:0]        tmr_lvl,
    input  logic [NSRC-1:0]        src_lvl,
    input  logic [CPU_W-1:0]       tgt_cpu,
    output logic [NCPU*WORD_W-1:0] pend_flat
);
    logic [CPU_W-1:0]  sel_cpu;
    reg_idx_e          sel_idx;
    logic [NCPU-1:0]   clr_sel, set_sel;
    logic [WORD_W-1:0] edge_set, edge_clr;
    logic [WORD_W-1:0] words [NCPU];

    pend_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_decode (
        .wen_i     (bus_wen),
        .addr_i    (bus_addr),
        .cpu_o     (sel_cpu),
        .idx_o     (sel_idx),
        .clr_sel_o (clr_sel),
        .set_sel_o (set_sel)
    );

    pend_src #(.NSRC(NSRC)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_lvl),
        .set_o (edge_set),
        .clr_o (edge_clr)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic hit;
        assign hit = (tgt_cpu == CPU_W'(c));
        pend_word #(.TMR_LEVEL(TMR_LEVEL)) u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr_sel[c]),
            .set_i     (set_sel[c]),
            .wdata_i   (bus_wdata),
            .src_set_i (hit ? edge_set : '0),
            .src_clr_i (hit ? edge_clr : '0),
            .tmr_i     (tmr_lvl[c]),
            .word_o    (words[c])
        );
        assign pend_flat[c*WORD_W +: WORD_W] = words[c];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_idx == IDX_VIEW) bus_rdata = words[sel_cpu];
    end

    always_comb begin
        assert_rsvd_reads_zero_R2: assert (sel_idx == IDX_VIEW || bus_rdata == '0);
    end
endmodule

// File: tb/pend_bank_bench.sv
module pend_bank_bench;
    localparam int NCPU = 16;
    localparam int NSRC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wen = 1'b0;
    logic [15:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   tmr_lvl = '0;
    logic [NSRC-1:0]   src_lvl = '0;
    logic [3:0]        tgt_cpu = '0;
    logic [NCPU*32-1:0] pend_flat;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pend_bank u_pend_bank (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_lvl(tmr_lvl),
        .src_lvl(src_lvl), .tgt_cpu(tgt_cpu), .pend_flat(pend_flat)
    );

    typedef struct packed {
        logic [3:0]  cpu;
        logic [1:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{cpu: 4'd3,  idx: 2'd2, data: 32'hFFFF_FFFF, exp: 32'hFFFE_0000}, // R4
        '{cpu: 4'd3,  idx: 2'd1, data: 32'h0F0F_0000, exp: 32'hF0F0_0000}, // R3
        '{cpu: 4'd3,  idx: 2'd0, data: 32'hFFFF_FFFF, exp: 32'hF0F0_0000}, // R5
        '{cpu: 4'd3,  idx: 2'd3, data: 32'hFFFF_FFFF, exp: 32'hF0F0_0000}, // R5
        '{cpu: 4'd3,  idx: 2'd2, data: 32'h0001_FFFF, exp: 32'hF0F0_0000}, // R4
        '{cpu: 4'd3,  idx: 2'd1, data: 32'h0000_FFFF, exp: 32'hF0F0_0000}, // R3
        '{cpu: 4'd15, idx: 2'd2, data: 32'h8002_0000, exp: 32'h8002_0000}, // R6
        '{cpu: 4'd0,  idx: 2'd2, data: 32'h1234_0000, exp: 32'h1234_0000}, // R6
        '{cpu: 4'd15, idx: 2'd1, data: 32'h8000_0000, exp: 32'h0002_0000}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_addr(input logic [3:0] cpu, input logic [1:0] idx);
        return {cpu, 8'h00, idx, 2'b00};
    endfunction

    task automatic bus_write(input logic [3:0] cpu, input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = mk_addr(cpu, idx); bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] cpu, input logic [1:0] idx, output logic [31:0] d);
        bus_addr = mk_addr(cpu, idx);
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        int pre_bad;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flat", pend_flat[31:0] | pend_flat[NCPU*32-1:NCPU*32-32], 32'h0);
        bus_read(4'd5, 2'd0, r); check("R1 read", r, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            bus_write(VECS[i].cpu, VECS[i].idx, VECS[i].data);
            bus_read(VECS[i].cpu, 2'd0, r);
            check("R3/R4/R5 vector", r, VECS[i].exp);
        end
        // R6: other windows untouched
        bus_read(4'd3, 2'd0, r); check("R6 cpu3", r, 32'hF0F0_0000);
        check("R6 flat cpu0", pend_flat[31:0], 32'h1234_0000);
        // R2: non-view indexes read zero
        bus_read(4'd3, 2'd1, r); check("R2 idx1", r, 32'h0);
        bus_read(4'd3, 2'd2, r); check("R2 idx2", r, 32'h0);
        bus_read(4'd3, 2'd3, r); check("R2 idx3", r, 32'h0);

        // R7: timer level follows
        @(negedge clk); tmr_lvl[5] = 1'b1;
        @(negedge clk);
        bus_read(4'd5, 2'd0, r); check("R7 timer set", r, 32'h0000_4000);
        // R3: software clear cannot remove timer bit
        bus_write(4'd5, 2'd1, 32'hFFFF_FFFF);
        bus_read(4'd5, 2'd0, r); check("R3 timer kept", r, 32'h0000_4000);
        // R9: timer drop with same-cycle bus set
        @(negedge clk);
        tmr_lvl[5] = 1'b0; bus_wen = 1'b1; bus_addr = mk_addr(4'd5, 2'd2); bus_wdata = 32'h8000_0000;
        @(negedge clk); bus_wen = 1'b0;
        bus_read(4'd5, 2'd0, r); check("R9 timer+set", r, 32'h8000_0000);

        // R8: request edges follow the target
        tgt_cpu = 4'd7; src_lvl[2] = 1'b1;
        @(negedge clk);
        bus_read(4'd7, 2'd0, r); check("R8 rise cpu7", r, 32'h0000_0008);
        tgt_cpu = 4'd1; src_lvl[2] = 1'b0;
        @(negedge clk);
        bus_read(4'd7, 2'd0, r); check("R8 fall keeps cpu7", r, 32'h0000_0008);
        bus_read(4'd1, 2'd0, r); check("R8 fall cpu1", r, 32'h0);
        src_lvl[2] = 1'b1;
        @(negedge clk);
        bus_read(4'd1, 2'd0, r); check("R8 rise cpu1", r, 32'h0000_0008);
        src_lvl[2] = 1'b0;
        @(negedge clk);
        bus_read(4'd1, 2'd0, r); check("R8 fall clears cpu1", r, 32'h0);
        // R9: request edge with same-cycle bus clear on cpu7
        tgt_cpu = 4'd7; src_lvl[0] = 1'b1;
        bus_wen = 1'b1; bus_addr = mk_addr(4'd7, 2'd1); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); bus_wen = 1'b0;
        bus_read(4'd7, 2'd0, r); check("R9 edge+clear", r, 32'h0000_000A);

        // R1: reset clears all words again
        rst_n = 1'b0;
        @(negedge clk);
        pre_bad = 0;
        for (int c = 0; c < NCPU; c++) if (pend_flat[c*32 +: 32] != 32'h0) pre_bad++;
        check("R1 reset all", 32'(pre_bad), 32'h0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule